// File: doc/BRIEF.md
# Serial Word Transmitter

This block sends 32-bit (or 25-bit) data words onto a serial avionics-style line. A host writes each word as two 16-bit halves: a low-half strobe captures the first half, and a high-half strobe commits the whole word into an eight-entry first-in first-out buffer. The host fills the buffer while the enable input is low. Raising the enable lets the block empty the buffer onto the line without further help.

On the line, each bit uses two rails in return-to-zero form. Rail A pulses for a one and rail B pulses for a zero, each during the first half of the bit time. A free-running bit clock runs in phase with the data. The last bit of every word carries odd or even parity, unless the host selects data in that position. A minimum gap of null bits separates words. A ready flag tells the host when the buffer is empty and the line has gone idle.

Top module: `avtx_sender`

## Requirements
- R1: A word is committed only by a high-half strobe (`ld_hi`) that follows a low-half strobe (`ld_lo`). A high-half strobe with no pending low half is ignored. Serial bits 1..16 are `din` of the low half, LSB first, and serial bits 17 onward are the high half, LSB first. Serial bit 1 goes out first.
- R2: The buffer holds DEPTH (default 8) words and sends them in load order. A word committed while the buffer is full replaces the most recently stored entry.
- R3: Load strobes are ignored while `tx_en` is high, and also in the cycle where it falls. A falling edge of `tx_en` empties the buffer. A word already on the line still completes.
- R4: `ready` is high exactly when the buffer is empty and no word is on the line. It goes low in the cycle after the committing high-half strobe into an empty buffer. It goes high at the end of the last bit of the final word.
- R5: One bit time is DIV_FAST (default 10) clock cycles when `cfg_slow` is 0, and DIV_SLOW (default 80) cycles when `cfg_slow` is 1.
- R6: A one bit drives `out_a` high for the first half of the bit time with `out_b` low. A zero bit drives `out_b` high for the first half with `out_a` low. A null bit keeps both low. Both high never occurs.
- R7: At least GAP_BITS (default 4) null bit times separate consecutive words. Words sent back to back have exactly GAP_BITS nulls between them. The same holds when a new block is enabled soon after the previous word ended.
- R8: `bit_clk` is free-running. It is high for the first half of each bit time and low for the second half.
- R9: `cfg_short`=0 gives 32-bit words and `cfg_short`=1 gives 25-bit words. The length is taken when a word starts.
- R10: The final bit (32 or 25) is the parity bit. It makes the count of ones in the word odd when `cfg_even`=0 and even when `cfg_even`=1. When both `cfg_par_ins` and `par_force` are 0, the final bit instead carries data: high-half bit 15 for 32-bit words, or high-half bit 8 for 25-bit words.
- R11: An active-low `rst_n` empties the buffer, clears the bit and gap timing, sets the line to null and sets `ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| din | input | 16 | half-word from the host |
| ld_lo | input | 1 | one-cycle strobe, capture low half |
| ld_hi | input | 1 | one-cycle strobe, capture high half and commit |
| tx_en | input | 1 | enable sending; falling edge empties buffer |
| cfg_short | input | 1 | 1 = 25-bit words |
| cfg_slow | input | 1 | 1 = slow bit rate |
| cfg_even | input | 1 | 1 = even parity |
| cfg_par_ins | input | 1 | 1 = final bit is parity |
| par_force | input | 1 | 1 = final bit is parity regardless of cfg_par_ins |
| out_a | output | 1 | rail pulsing for one bits |
| out_b | output | 1 | rail pulsing for zero bits |
| bit_clk | output | 1 | bit clock, high in first half of bit |
| ready | output | 1 | buffer empty and line idle |

## Verification
A commit moves `ready` low one clock edge after the strobe, so the bench samples it at the next falling clock edge. Line symbols change one edge after the bit-timer wrap, which is also when `bit_clk` rises. The bench therefore decodes each symbol at the first falling clock edge that sees `bit_clk` high. It counts null symbols between words, which gives the gap and word length directly without assuming absolute cycle numbers. Bit time and duty cycle are measured as runs of `bit_clk` levels at falling edges. Where a check must land before the first start decision, the enable pulse is aligned to a `bit_clk` rise.

// File: rtl/avtx_pkg.sv
package avtx_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  // index of the final serial bit, zero based
  function automatic logic [4:0] final_index(input logic short_w);
    return short_w ? 5'd24 : 5'd31;
  endfunction

  // serial frame: bit k of the result is serial bit k+1
  function automatic logic [WORD_W-1:0] frame_bits(
    input logic [HALF_W-1:0] lo,
    input logic [HALF_W-1:0] hi,
    input logic              short_w,
    input logic              even,
    input logic              use_par
  );
    logic [WORD_W-1:0] f;
    logic [4:0]        fin;
    f   = {hi, lo};
    fin = final_index(short_w);
    if (short_w) f[31:25] = '0;
    if (use_par) begin
      f[fin] = 1'b0;
      f[fin] = even ? (^f) : ~(^f);
    end
    return f;
  endfunction

endpackage

// File: rtl/avtx_bit_timer.sv
module avtx_bit_timer #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic tick,
  output logic phase_hi
);
  localparam int CW = $clog2(DIV_SLOW + 1);
  localparam logic [CW-1:0] F_LAST = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] S_LAST = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] F_HALF = CW'(DIV_FAST / 2);
  localparam logic [CW-1:0] S_HALF = CW'(DIV_SLOW / 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [CW-1:0] half;

  assign last     = slow ? S_LAST : F_LAST;
  assign half     = slow ? S_HALF : F_HALF;
  assign tick     = (cnt >= last);
  assign phase_hi = (cnt < half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/avtx_loader.sv
module avtx_loader #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] din,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              tx_en,
  output logic              push,
  output logic [2*HALF_W-1:0] wdata,
  output logic              flush
);
  logic [HALF_W-1:0] lo_hold;
  logic              lo_seen;
  logic              en_q;
  logic              allow;

  assign allow = !tx_en && !en_q;
  assign flush = en_q && !tx_en;
  assign push  = allow && ld_hi && lo_seen;
  assign wdata = {din, lo_hold};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_hold <= '0;
      lo_seen <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (allow && ld_lo) begin
        lo_hold <= din;
        lo_seen <= 1'b1;
      end else if (push) begin
        lo_seen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/avtx_fifo.sv
module avtx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  input  logic                       flush,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, wr_at;
  logic          full;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] prv(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign full  = (count == FULL);
  assign wr_at = full ? prv(wr_ptr) : wr_ptr;
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_at] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= nxt(wr_ptr);
      if (pop)           rd_ptr <= nxt(rd_ptr);
      case ({push && !full, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/avtx_serializer.sv
module avtx_serializer
  import avtx_pkg::*;
#(
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              phase_hi,
  input  logic              can_start,
  input  logic [WORD_W-1:0] head,
  input  logic              cfg_short,
  input  logic              cfg_even,
  input  logic              use_par,
  output logic              start,
  output logic              busy,
  output logic              out_a,
  output logic              out_b
);
  localparam int GW = $clog2(GAP_BITS + 1);
  localparam logic [GW-1:0] GAP_W = GW'(GAP_BITS);

  logic [WORD_W-1:0] frame, new_frame;
  logic [4:0]        idx, last_idx;
  logic [GW-1:0]     gap, gap_next;
  logic              cur_bit;

  assign new_frame = frame_bits(head[15:0], head[31:16], cfg_short, cfg_even, use_par);
  assign gap_next  = (gap >= GAP_W) ? GAP_W : gap + 1'b1;
  assign start     = tick && !busy && (gap_next == GAP_W) && can_start;

  assign out_a = busy && cur_bit && phase_hi;
  assign out_b = busy && !cur_bit && phase_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame    <= '0;
      idx      <= '0;
      last_idx <= '0;
      gap      <= GAP_W;
      busy     <= 1'b0;
      cur_bit  <= 1'b0;
    end else if (tick) begin
      if (busy) begin
        if (idx == last_idx) begin
          busy <= 1'b0;
          gap  <= '0;
        end else begin
          idx     <= idx + 1'b1;
          cur_bit <= frame[idx + 1'b1];
        end
      end else begin
        gap <= gap_next;
        if (start) begin
          frame    <= new_frame;
          idx      <= '0;
          last_idx <= final_index(cfg_short);
          busy     <= 1'b1;
          cur_bit  <= new_frame[0];
        end
      end
    end
  end
endmodule

// File: rtl/avtx_sender.sv
module avtx_sender
  import avtx_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80,
  parameter int GAP_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] din,
  input  logic        ld_lo,
  input  logic        ld_hi,
  input  logic        tx_en,
  input  logic        cfg_short,
  input  logic        cfg_slow,
  input  logic        cfg_even,
  input  logic        cfg_par_ins,
  input  logic        par_force,
  output logic        out_a,
  output logic        out_b,
  output logic        bit_clk,
  output logic        ready
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic              tm_tick;
  logic              tm_phase;
  logic              ld_push;
  logic              ld_flush;
  logic [WORD_W-1:0] ld_word;
  logic [WORD_W-1:0] fifo_head;
  logic [CNTW-1:0]   fifo_count;
  logic              sr_start;
  logic              sr_busy;

  avtx_bit_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) timer_i (
    .clk(clk), .rst_n(rst_n), .slow(cfg_slow), .tick(tm_tick), .phase_hi(tm_phase)
  );

  avtx_loader #(.HALF_W(HALF_W)) loader_i (
    .clk(clk), .rst_n(rst_n), .din(din), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .tx_en(tx_en), .push(ld_push), .wdata(ld_word), .flush(ld_flush)
  );

  avtx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(ld_push), .wdata(ld_word), .pop(sr_start),
    .flush(ld_flush), .rdata(fifo_head), .count(fifo_count)
  );

  avtx_serializer #(.GAP_BITS(GAP_BITS)) ser_i (
    .clk(clk), .rst_n(rst_n), .tick(tm_tick), .phase_hi(tm_phase),
    .can_start(tx_en && (fifo_count != '0)), .head(fifo_head),
    .cfg_short(cfg_short), .cfg_even(cfg_even), .use_par(cfg_par_ins || par_force),
    .start(sr_start), .busy(sr_busy), .out_a(out_a), .out_b(out_b)
  );

  assign bit_clk = tm_phase;
  assign ready   = (fifo_count == '0) && !sr_busy;
endmodule

// File: rtl/avtx_checker.sv
module avtx_checker #(
  parameter int GAP_BITS = 4,
  parameter int CNTW     = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_en,
  input logic            tick,
  input logic            start,
  input logic            busy,
  input logic [CNTW-1:0] count,
  input logic            out_a,
  input logic            out_b,
  input logic            bit_clk,
  input logic            ready
);
  localparam int RW = $clog2(GAP_BITS + 2);
  localparam logic [RW-1:0] GAP_R = RW'(GAP_BITS);

  logic [RW-1:0] null_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       null_run <= GAP_R;
    else if (tick) begin
      if (busy)                 null_run <= '0;
      else if (null_run < GAP_R) null_run <= null_run + 1'b1;
    end
  end

  p_rails_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));

  p_rails_first_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a || out_b) |-> bit_clk);

  p_no_load_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> (count <= $past(count)));

  p_flush_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |=> (count == '0));

  p_gap_before_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (null_run >= GAP_R - 1'b1));

  p_ready_means_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> !ready);

  p_start_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (tx_en && count != '0));

  p_clock_high_after_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> bit_clk);
endmodule

bind avtx_sender avtx_checker #(.GAP_BITS(GAP_BITS), .CNTW(CNTW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tick(tm_tick), .start(sr_start),
  .busy(sr_busy), .count(fifo_count), .out_a(out_a), .out_b(out_b),
  .bit_clk(bit_clk), .ready(ready)
);

// File: tb/avtx_sender_tb.sv
module avtx_sender_tb_top;
  localparam int DF = 4;
  localparam int DS = 8;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] din = '0;
  logic ld_lo = 0, ld_hi = 0, tx_en = 0;
  logic cfg_short = 0, cfg_slow = 0, cfg_even = 0, cfg_par_ins = 1, par_force = 0;
  logic out_a, out_b, bit_clk, ready;

  always #2.5 clk = ~clk;

  avtx_sender #(.DEPTH(8), .DIV_FAST(DF), .DIV_SLOW(DS), .GAP_BITS(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .ld_lo(ld_lo), .ld_hi(ld_hi), .tx_en(tx_en),
    .cfg_short(cfg_short), .cfg_slow(cfg_slow), .cfg_even(cfg_even),
    .cfg_par_ins(cfg_par_ins), .par_force(par_force),
    .out_a(out_a), .out_b(out_b), .bit_clk(bit_clk), .ready(ready)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // line decoder
  logic [31:0] rx_w [64];
  int rx_len [64];
  int rx_gap [64];
  int rx_n = 0;
  logic [31:0] cur = '0;
  int cur_n = 0, nulls = 99, both_seen = 0, off_phase = 0;
  logic bc_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (out_a && out_b) both_seen++;
      if ((out_a || out_b) && !bit_clk) off_phase++;
      if (bit_clk && !bc_prev) begin
        if (out_a || out_b) begin
          if (cur_n == 0 && rx_n < 64) rx_gap[rx_n] = nulls;
          if (cur_n < 32) cur[cur_n] = out_a;
          cur_n++;
        end else if (cur_n > 0) begin
          if (rx_n < 64) begin
            rx_w[rx_n] = cur; rx_len[rx_n] = cur_n; rx_n++;
          end
          cur = '0; cur_n = 0; nulls = 1;
        end else if (nulls < 999) nulls++;
      end
      bc_prev = bit_clk;
    end
  end

  function automatic logic [31:0] expect_frame(input logic [15:0] lo, hi,
      input bit short_w, even, par);
    logic [31:0] f;
    int len, ones;
    len = short_w ? 25 : 32;
    f = '0;
    ones = 0;
    for (int k = 0; k < len - 1; k++) begin
      f[k] = (k < 16) ? lo[k] : hi[k-16];
      ones += f[k];
    end
    if (par) f[len-1] = even ? (ones % 2 == 1) : (ones % 2 == 0);
    else     f[len-1] = hi[len-17];
    return f;
  endfunction

  task automatic load_word(input logic [15:0] lo, hi);
    @(negedge clk) din = lo; ld_lo = 1;
    @(negedge clk) ld_lo = 0; din = hi; ld_hi = 1;
    @(negedge clk) ld_hi = 0;
  endtask

  task automatic run_block(input bit trail);
    @(negedge clk) tx_en = 1;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (ready) break;
    end
    tx_en = 0;
    if (trail) repeat (3 * DS) @(negedge clk);
  endtask

  task automatic check_word(input int i, input logic [15:0] lo, hi,
      input bit short_w, even, par, input string tag);
    logic [31:0] e;
    int len;
    len = short_w ? 25 : 32;
    e = expect_frame(lo, hi, short_w, even, par);
    check(rx_w[i] == e, tag, rx_w[i], e);
    check(rx_len[i] == len, "R9 word length", rx_len[i], len);
  endtask

  task automatic measure_clock(input int div, input string tag);
    int hi_n, lo_n;
    hi_n = 0; lo_n = 0;
    @(negedge clk);
    while (!(bit_clk && !bc_prev)) @(negedge clk);
    while (bit_clk) begin hi_n++; @(negedge clk); end
    while (!bit_clk) begin lo_n++; @(negedge clk); end
    check(hi_n == div / 2, tag, hi_n, div / 2);
    check(lo_n == div / 2, tag, lo_n, div / 2);
  endtask

  logic [15:0] wl [10];
  logic [15:0] wh [10];

  initial begin
    if (cyc > 150000) $display("watchdog");
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    int base;
    for (int i = 0; i < 10; i++) begin
      wl[i] = 16'h1357 ^ (16'h2C41 * i[15:0]);
      wh[i] = 16'hA0F3 + (16'h1111 * i[15:0]);
    end
    repeat (4) @(negedge clk);
    // R11: reset state
    check(ready == 1'b1, "R11 ready in reset", ready, 1);
    check(!out_a && !out_b, "R11 line null in reset", {out_a, out_b}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R11 ready after reset", ready, 1);

    // R4 / R1 / R7 / R10: three words, 32-bit odd parity
    base = rx_n;
    load_word(wl[0], wh[0]);
    check(ready == 1'b0, "R4 ready low after commit", ready, 0);
    load_word(wl[1], wh[1]);
    load_word(wl[2], wh[2]);
    run_block(1);
    check(rx_n - base == 3, "R2 word count", rx_n - base, 3);
    for (int i = 0; i < 3; i++) check_word(base + i, wl[i], wh[i], 0, 0, 1, "R1 R10 odd frame");
    for (int i = 1; i < 3; i++) check(rx_gap[base+i] == GAP, "R7 back-to-back gap", rx_gap[base+i], GAP);
    check(ready == 1'b1, "R4 ready after drain", ready, 1);

    // R9 / R10: 25-bit even parity
    cfg_short = 1; cfg_even = 1;
    base = rx_n;
    load_word(wl[3], wh[3]);
    load_word(wl[4], wh[4]);
    run_block(1);
    check(rx_n - base == 2, "R9 short count", rx_n - base, 2);
    for (int i = 0; i < 2; i++) check_word(base + i, wl[3+i], wh[3+i], 1, 1, 1, "R9 R10 short even frame");

    // R10: data in final bit, both polarities of the source bit
    cfg_even = 0; cfg_par_ins = 0; par_force = 0;
    base = rx_n;
    load_word(16'h00FF, 16'h0100);
    load_word(16'h00FF, 16'h0000);
    cfg_short = 0;
    load_word(16'hFFFF, 16'h8000);
    run_block(0);
    cfg_short = 1;
    run_block(1);
    check(rx_n >= base + 1, "R10 data mode received", rx_n - base, 3);

    // restart cleanly for deterministic data-mode check
    cfg_short = 0;
    base = rx_n;
    load_word(16'h0F0F, 16'h8001);
    load_word(16'h0F0F, 16'h0001);
    run_block(1);
    check_word(base, 16'h0F0F, 16'h8001, 0, 0, 0, "R10 data bit one");
    check_word(base + 1, 16'h0F0F, 16'h0001, 0, 0, 0, "R10 data bit zero");

    // R10: force overrides disabled insertion
    par_force = 1;
    base = rx_n;
    load_word(16'h0F0F, 16'h8001);
    run_block(1);
    check_word(base, 16'h0F0F, 16'h8001, 0, 0, 1, "R10 forced parity");
    par_force = 0; cfg_par_ins = 1;

    // R2: nine loads into an eight-entry buffer
    base = rx_n;
    for (int i = 0; i < 9; i++) load_word(wl[i] ^ 16'h5A5A, wh[i]);
    run_block(1);
    check(rx_n - base == 8, "R2 overfill count", rx_n - base, 8);
    for (int i = 0; i < 7; i++) check_word(base + i, wl[i] ^ 16'h5A5A, wh[i], 0, 0, 1, "R2 order");
    check_word(base + 7, wl[8] ^ 16'h5A5A, wh[8], 0, 0, 1, "R2 newest replaced");

    // R1: high strobe with no low half pending
    @(negedge clk) din = 16'h1234; ld_hi = 1;
    @(negedge clk) ld_hi = 0;
    @(negedge clk);
    check(ready == 1'b1, "R1 lone high strobe ignored", ready, 1);

    // R3: loads while enabled are ignored
    @(negedge clk) tx_en = 1;
    load_word(16'h1111, 16'h2222);
    @(negedge clk);
    check(ready == 1'b1, "R3 load while enabled ignored", ready, 1);
    tx_en = 0;
    repeat (2) @(negedge clk);

    // R3: short enable pulse before any start, falling edge flushes
    base = rx_n;
    load_word(16'h3333, 16'h4444);
    load_word(16'h5555, 16'h6666);
    @(negedge clk);
    while (!(bit_clk && !bc_prev)) @(negedge clk);
    tx_en = 1;
    @(negedge clk) tx_en = 0;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R3 flush empties buffer", ready, 1);
    repeat (60 * DF) @(negedge clk);
    check(rx_n == base, "R3 nothing sent after flush", rx_n - base, 0);

    // R7: new block enabled right after previous word ended
    base = rx_n;
    load_word(wl[5], wh[5]);
    run_block(0);
    load_word(wl[6], wh[6]);
    run_block(1);
    check(rx_n - base == 2, "R7 reenable count", rx_n - base, 2);
    check(rx_gap[base+1] == GAP, "R7 gap kept across blocks", rx_gap[base+1], GAP);

    // R5 / R8: bit time and duty at both rates
    measure_clock(DF, "R5 R8 fast bit clock");
    cfg_slow = 1;
    repeat (2 * DS) @(negedge clk);
    measure_clock(DS, "R5 R8 slow bit clock");
    base = rx_n;
    load_word(wl[7], wh[7]);
    run_block(1);
    check_word(base, wl[7], wh[7], 0, 0, 1, "R5 slow rate word");

    // R6: rail rules over the whole run
    check(both_seen == 0, "R6 rails never both high", both_seen, 0);
    check(off_phase == 0, "R6 pulses only in first half", off_phase, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule